// File: doc/BRIEF.md
# Interlocked Asynchronous Read Link

This block carries one word from a memory responder to a requesting I/O device over a shared set of bidirectional lines, using three control wires: a request from the device, an acknowledge that both sides use in turn, and a data-ready strobe from memory. The same lines carry the address toward memory and the data back, so only one side drives them at any moment. Every edge of every control wire is answered by the other side before the next step is taken. Because of this, neither side depends on the other's speed, and the two sides could sit in unrelated clock domains. Each side passes the other side's control wires through a multi-flop synchronizer before it acts on them.

The device side accepts a start pulse with an address, runs the handshake and returns the word with a done pulse. A programmable wait limit makes it give up when an expected edge never arrives, and it flags an error when it does. The memory side captures the address, launches a read on a synchronous array port with a fixed access latency, and lets the acknowledge steps run while that read is in flight. It does not assert data-ready until the array word has been captured. Both state machines sit in one top module, and the top brings the shared lines and control wires out to its ports for observation.

Top module: `abus_read_link`

## Requirements
- R1: A start pulse while the link is idle makes the device raise the request, drive the address onto the low bits of the shared lines (upper bits zero) and raise busy, all visible in the cycle after the start.
- R2: When memory sees the request, it captures the address, raises acknowledge and issues exactly one single-cycle array read on that address.
- R3: The device keeps the request asserted until it sees acknowledge, then drops the request and stops driving the lines in the same cycle. The only exception is a timeout.
- R4: Memory raises data-ready, while driving the read word, only after it has seen the request low and the acknowledge low. It holds data-ready until it sees acknowledge high again.
- R5: The device and memory never drive the shared lines in the same cycle.
- R6: A transaction produces the control-wire edges in this order: request rise, acknowledge rise, request fall, acknowledge fall, data-ready rise, acknowledge rise, data-ready fall, acknowledge fall.
- R7: The returned word is the array word for the requested address. Memory samples it in the cycle that comes LAT cycles after the array-read cycle.
- R8: A transaction ends with a one-cycle done pulse with error low, and busy then falls. This happens only after the device has seen the final acknowledge fall.
- R9: A start pulse while busy is ignored. It issues no new request and no array read, and it does not change the returned word.
- R10: With a nonzero wait limit L, a device that stays more than L cycles in one handshake step ends the transaction. It pulses done and error together, drops its request and acknowledge, releases the lines and leaves the returned word unchanged.
- R11: A wait limit of zero turns the timeout off.
- R12: Each side acts on a control edge exactly SYNC+1 clock edges after that edge appears. With the default SYNC=2, the first acknowledge rise comes three cycles after the request rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a read (device side) |
| start_addr | input | AW | Address for the read |
| tmo_limit | input | TW | Wait limit per handshake step; 0 disables |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| err | output | 1 | Timeout flag, pulses with done |
| rd_data | output | DW | Last word returned |
| arr_rd | output | 1 | Array read strobe (memory side) |
| arr_addr | output | AW | Array read address |
| arr_rdata | input | DW | Array read word, valid LAT cycles after the strobe |
| bus_req | output | 1 | Request wire |
| bus_ack | output | 1 | Acknowledge wire (either side) |
| bus_rdy | output | 1 | Data-ready wire |
| bus_data | output | DW | Shared address/data lines |
| dev_drive | output | 1 | Device is driving the lines |
| mem_drive | output | 1 | Memory is driving the lines |

## Verification
A state machine that skips a step shows up at once in the order of control edges on the wires. For example, data-ready would rise while the request is still high, or acknowledge would rise twice in a row, and the bench sees this within the same transaction. A latency counter that is off by one samples the array model outside its valid window, so the returned word is wrong by the end of that read. A missing synchronizer stage moves the first acknowledge off its three-cycle spacing. A broken wait counter either stalls the link until the watchdog ends the run or makes an error pulse appear where none belongs.

// File: rtl/abus_pkg.sv
package abus_pkg;

  typedef enum logic [2:0] {
    D_IDLE,
    D_REQ,
    D_WRDY,
    D_WRDYLO,
    D_WACKLO
  } dev_state_t;

  typedef enum logic [2:0] {
    M_IDLE,
    M_REQLO,
    M_DATA,
    M_ACKHI,
    M_ACKLO
  } mem_state_t;

endpackage

// File: rtl/abus_sync.sv
module abus_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        st[i] <= st[i-1];
      end
    end
  end

  assign q = st[STAGES-1];

endmodule

// File: rtl/abus_dev_side.sv
module abus_dev_side
  import abus_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int TW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [TW-1:0] tmo_limit,
  input  logic          ack_in,
  input  logic          rdy_in,
  input  logic [DW-1:0] bus_in,
  output logic          req_o,
  output logic          ack_o,
  output logic          drv_o,
  output logic [DW-1:0] bus_o,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rd_data
);

  dev_state_t    state;
  logic [AW-1:0] addr_q;
  logic [TW-1:0] wait_cnt;
  logic [1:0]    ctl_s;
  logic          ack_s;
  logic          rdy_s;
  logic          tmo_hit;

  abus_sync #(.W(2), .STAGES(SYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ack_in, rdy_in}),
    .q   (ctl_s)
  );

  assign ack_s   = ctl_s[1];
  assign rdy_s   = ctl_s[0];
  assign tmo_hit = (state != D_IDLE) && (tmo_limit != '0) && (wait_cnt == tmo_limit);
  assign bus_o   = DW'(addr_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= D_IDLE;
      addr_q   <= '0;
      wait_cnt <= '0;
      req_o    <= 1'b0;
      ack_o    <= 1'b0;
      drv_o    <= 1'b0;
      busy     <= 1'b0;
      done     <= 1'b0;
      err      <= 1'b0;
      rd_data  <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (state == D_IDLE) begin
        wait_cnt <= '0;
        if (start) begin
          addr_q <= start_addr;
          req_o  <= 1'b1;
          drv_o  <= 1'b1;
          busy   <= 1'b1;
          state  <= D_REQ;
        end
      end else if (tmo_hit) begin
        req_o    <= 1'b0;
        drv_o    <= 1'b0;
        ack_o    <= 1'b0;
        busy     <= 1'b0;
        done     <= 1'b1;
        err      <= 1'b1;
        wait_cnt <= '0;
        state    <= D_IDLE;
      end else begin
        wait_cnt <= wait_cnt + TW'(1);
        case (state)
          D_REQ: begin
            if (ack_s) begin
              req_o    <= 1'b0;
              drv_o    <= 1'b0;
              wait_cnt <= '0;
              state    <= D_WRDY;
            end
          end
          D_WRDY: begin
            if (rdy_s) begin
              rd_data  <= bus_in;
              ack_o    <= 1'b1;
              wait_cnt <= '0;
              state    <= D_WRDYLO;
            end
          end
          D_WRDYLO: begin
            if (!rdy_s) begin
              ack_o    <= 1'b0;
              wait_cnt <= '0;
              state    <= D_WACKLO;
            end
          end
          D_WACKLO: begin
            if (!ack_s) begin
              busy     <= 1'b0;
              done     <= 1'b1;
              wait_cnt <= '0;
              state    <= D_IDLE;
            end
          end
          default: state <= D_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/abus_mem_side.sv
module abus_mem_side
  import abus_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int LAT  = 3,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_in,
  input  logic          ack_in,
  input  logic [AW-1:0] bus_in,
  output logic          ack_o,
  output logic          rdy_o,
  output logic          drv_o,
  output logic [DW-1:0] bus_o,
  output logic          arr_rd,
  output logic [AW-1:0] arr_addr,
  input  logic [DW-1:0] arr_rdata
);

  localparam int LW = $clog2(LAT + 1);

  mem_state_t    state;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [LW-1:0] lat_cnt;
  logic          pend;
  logic [1:0]    ctl_s;
  logic          req_s;
  logic          ack_s;

  abus_sync #(.W(2), .STAGES(SYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({req_in, ack_in}),
    .q   (ctl_s)
  );

  assign req_s    = ctl_s[1];
  assign ack_s    = ctl_s[0];
  assign bus_o    = data_q;
  assign arr_addr = addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= M_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      lat_cnt <= '0;
      pend    <= 1'b0;
      ack_o   <= 1'b0;
      rdy_o   <= 1'b0;
      drv_o   <= 1'b0;
      arr_rd  <= 1'b0;
    end else begin
      arr_rd <= 1'b0;
      if (pend) begin
        if (lat_cnt != '0) begin
          lat_cnt <= lat_cnt - LW'(1);
        end else begin
          data_q <= arr_rdata;
          pend   <= 1'b0;
        end
      end
      case (state)
        M_IDLE: begin
          if (req_s) begin
            addr_q  <= bus_in;
            ack_o   <= 1'b1;
            arr_rd  <= 1'b1;
            lat_cnt <= LW'(LAT);
            pend    <= 1'b1;
            state   <= M_REQLO;
          end
        end
        M_REQLO: begin
          if (!req_s) begin
            ack_o <= 1'b0;
            state <= M_DATA;
          end
        end
        M_DATA: begin
          if (!pend && !ack_s) begin
            drv_o <= 1'b1;
            rdy_o <= 1'b1;
            state <= M_ACKHI;
          end
        end
        M_ACKHI: begin
          if (ack_s) begin
            drv_o <= 1'b0;
            rdy_o <= 1'b0;
            state <= M_ACKLO;
          end
        end
        M_ACKLO: begin
          if (!ack_s) begin
            state <= M_IDLE;
          end
        end
        default: state <= M_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/abus_read_link.sv
module abus_read_link #(
  parameter int AW   = 16,
  parameter int DW   = 32,
  parameter int LAT  = 3,
  parameter int TW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] start_addr,
  input  logic [TW-1:0] tmo_limit,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [DW-1:0] rd_data,
  output logic          arr_rd,
  output logic [AW-1:0] arr_addr,
  input  logic [DW-1:0] arr_rdata,
  output logic          bus_req,
  output logic          bus_ack,
  output logic          bus_rdy,
  output logic [DW-1:0] bus_data,
  output logic          dev_drive,
  output logic          mem_drive
);

  logic          dev_req;
  logic          dev_ack;
  logic          dev_drv;
  logic [DW-1:0] dev_out;
  logic          mem_ack;
  logic          mem_rdy;
  logic          mem_drv;
  logic [DW-1:0] mem_out;
  logic [DW-1:0] shared;
  logic          ack_wire;

  assign ack_wire = dev_ack | mem_ack;
  assign shared   = dev_drv ? dev_out : (mem_drv ? mem_out : '0);

  abus_dev_side #(.AW(AW), .DW(DW), .TW(TW), .SYNC(SYNC)) u_dev (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .start_addr (start_addr),
    .tmo_limit  (tmo_limit),
    .ack_in     (ack_wire),
    .rdy_in     (mem_rdy),
    .bus_in     (shared),
    .req_o      (dev_req),
    .ack_o      (dev_ack),
    .drv_o      (dev_drv),
    .bus_o      (dev_out),
    .busy       (busy),
    .done       (done),
    .err        (err),
    .rd_data    (rd_data)
  );

  abus_mem_side #(.AW(AW), .DW(DW), .LAT(LAT), .SYNC(SYNC)) u_mem (
    .clk       (clk),
    .rst       (rst),
    .req_in    (dev_req),
    .ack_in    (ack_wire),
    .bus_in    (shared[AW-1:0]),
    .ack_o     (mem_ack),
    .rdy_o     (mem_rdy),
    .drv_o     (mem_drv),
    .bus_o     (mem_out),
    .arr_rd    (arr_rd),
    .arr_addr  (arr_addr),
    .arr_rdata (arr_rdata)
  );

  assign bus_req   = dev_req;
  assign bus_ack   = ack_wire;
  assign bus_rdy   = mem_rdy;
  assign bus_data  = shared;
  assign dev_drive = dev_drv;
  assign mem_drive = mem_drv;

endmodule

// File: rtl/abus_read_link_chk.sv
module abus_read_link_chk (
  input logic clk,
  input logic rst,
  input logic start,
  input logic busy,
  input logic done,
  input logic err,
  input logic arr_rd,
  input logic bus_req,
  input logic bus_ack,
  input logic bus_rdy,
  input logic dev_drive,
  input logic mem_drive
);

  a_r1_start_request: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> (bus_req && dev_drive && busy));

  a_r2_read_pulse: assert property (@(posedge clk) disable iff (rst)
    arr_rd |=> !arr_rd);

  a_r3_req_until_ack: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_ack) |=> (bus_req || err));

  a_r4_rdy_after_req_low: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_rdy) |-> (!bus_req && !bus_ack && mem_drive));

  a_r4_rdy_held: assert property (@(posedge clk) disable iff (rst)
    (bus_rdy && !bus_ack) |=> bus_rdy);

  a_r5_single_driver: assert property (@(posedge clk) disable iff (rst)
    !(dev_drive && mem_drive));

  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && !bus_req));

  a_r9_req_from_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> $rose(busy));

  a_r10_err_with_done: assert property (@(posedge clk) disable iff (rst)
    err |-> done);

  a_r12_ack_sync_delay: assert property (@(posedge clk) disable iff (rst)
    ($rose(bus_ack) && bus_req) |-> $past(bus_req, 2));

endmodule

bind abus_read_link abus_read_link_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .arr_rd    (arr_rd),
  .bus_req   (bus_req),
  .bus_ack   (bus_ack),
  .bus_rdy   (bus_rdy),
  .dev_drive (dev_drive),
  .mem_drive (mem_drive)
);

// File: tb/abus_read_link_test.sv
`timescale 1ns/1ps
module abus_read_link_test;

  localparam int AW   = 16;
  localparam int DW   = 32;
  localparam int LAT  = 3;
  localparam int TW   = 8;
  localparam int SYNC = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [TW-1:0] tmo_limit = '0;
  logic          busy, done, err;
  logic [DW-1:0] rd_data;
  logic          arr_rd;
  logic [AW-1:0] arr_addr;
  logic [DW-1:0] arr_rdata;
  logic          bus_req, bus_ack, bus_rdy;
  logic [DW-1:0] bus_data;
  logic          dev_drive, mem_drive;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  abus_read_link #(.AW(AW), .DW(DW), .LAT(LAT), .TW(TW), .SYNC(SYNC)) uut (
    .clk (clk), .rst (rst), .start (start), .start_addr (start_addr),
    .tmo_limit (tmo_limit), .busy (busy), .done (done), .err (err),
    .rd_data (rd_data), .arr_rd (arr_rd), .arr_addr (arr_addr),
    .arr_rdata (arr_rdata), .bus_req (bus_req), .bus_ack (bus_ack),
    .bus_rdy (bus_rdy), .bus_data (bus_data), .dev_drive (dev_drive),
    .mem_drive (mem_drive)
  );

  function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
    return {~a, a} ^ 32'h5A5A_0F0F;
  endfunction

  // array model: word valid only in the cycle LAT cycles after the strobe
  logic [LAT-1:0]         pv;
  logic [LAT-1:0][AW-1:0] pa;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      pv <= '0;
      pa <= '0;
    end else begin
      pv[0] <= arr_rd;
      pa[0] <= arr_addr;
      for (int i = 1; i < LAT; i++) begin
        pv[i] <= pv[i-1];
        pa[i] <= pa[i-1];
      end
    end
  end
  assign arr_rdata = pv[LAT-1] ? word_at(pa[LAT-1]) : 32'hDEAD_BEEF;

  // port monitor
  int ev [16];
  int ev_n = 0;
  int rd_cnt = 0;
  int clash = 0;
  int req_t = 0;
  int ack_t = 0;
  logic [DW-1:0] rdy_word = '0;
  logic rdy_md = 1'b0;
  logic p_req = 1'b0, p_ack = 1'b0, p_rdy = 1'b0;

  function automatic void push(input int code);
    if (ev_n < 16) ev[ev_n] = code;
    ev_n++;
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (bus_req && !p_req) begin push(1); req_t = cyc; end
      if (!bus_req && p_req) push(2);
      if (bus_ack && !p_ack) begin push(3); if (bus_req) ack_t = cyc; end
      if (!bus_ack && p_ack) push(4);
      if (bus_rdy && !p_rdy) begin push(5); rdy_word = bus_data; rdy_md = mem_drive; end
      if (!bus_rdy && p_rdy) push(6);
      if (dev_drive && mem_drive) clash++;
      if (arr_rd) rd_cnt++;
    end
    p_req = bus_req;
    p_ack = bus_ack;
    p_rdy = bus_rdy;
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  // runs one read; R1 checked one cycle after the start pulse
  task automatic do_read(input logic [AW-1:0] a, input logic [TW-1:0] lim,
                         output logic [DW-1:0] d, output logic e, output bit seen);
    @(negedge clk);
    ev_n = 0;
    rd_cnt = 0;
    tmo_limit = lim;
    start_addr = a;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1", "req/drive/busy", {61'd0, bus_req, dev_drive, busy}, 64'h7);
    chk("R1", "address on lines", bus_data, {{(DW-AW){1'b0}}, a});
    seen = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    d = rd_data;
    e = err;
  endtask

  task automatic test_reset();
    chk("R8", "reset outputs",
        {56'd0, busy, done, err, bus_req, bus_ack, bus_rdy, dev_drive, mem_drive}, 64'h0);
    chk("R7", "reset word", rd_data, 64'h0);
  endtask

  task automatic test_read(input logic [AW-1:0] a);
    logic [DW-1:0] d;
    logic e;
    bit seen;
    int exp_ev [8] = '{1, 3, 2, 4, 5, 3, 6, 4};
    int bad;
    do_read(a, 8'd50, d, e, seen);
    chk("R8", "done seen", seen, 1);
    chk("R8", "no error", e, 0);
    chk("R7", "returned word", d, word_at(a));
    chk("R2", "one array read", rd_cnt, 1);
    chk("R4", "word on lines at data-ready", {rdy_md, rdy_word}, {1'b1, word_at(a)});
    chk("R12", "ack spacing", ack_t - req_t, SYNC + 1);
    chk("R6", "edge count", ev_n, 8);
    bad = 0;
    for (int i = 0; i < 8; i++) if (ev[i] != exp_ev[i]) bad++;
    chk("R6", "edge order mismatches", bad, 0);
    @(negedge clk);
    chk("R8", "done is a pulse, busy low", {done, busy}, 0);
  endtask

  task automatic test_busy_start();
    logic [AW-1:0] a = 16'h0A5C;
    bit seen = 1'b0;
    @(negedge clk);
    ev_n = 0; rd_cnt = 0; tmo_limit = 8'd50;
    start_addr = a; start = 1'b1;
    @(negedge clk);
    start_addr = 16'h7777;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (done) begin seen = 1'b1; break; end
      @(negedge clk);
    end
    chk("R9", "done seen", seen, 1);
    chk("R9", "word of first address", rd_data, word_at(a));
    repeat (10) @(negedge clk);
    chk("R9", "single array read", rd_cnt, 1);
    chk("R9", "no new request", {busy, bus_req}, 0);
  endtask

  task automatic test_timeout(input logic [TW-1:0] lim);
    logic [DW-1:0] d, prev;
    logic e;
    bit seen;
    prev = rd_data;
    do_read(16'h0F0F, lim, d, e, seen);
    chk("R10", "done seen", seen, 1);
    chk("R10", "error flagged", e, 1);
    chk("R10", "word unchanged", d, prev);
    chk("R10", "request and drive dropped", {bus_req, dev_drive, busy}, 0);
    do_reset();
  endtask

  task automatic test_no_timeout();
    logic [DW-1:0] d;
    logic e;
    bit seen;
    do_read(16'h3C3C, 8'd0, d, e, seen);
    chk("R11", "limit zero completes", {seen, e}, 2'b10);
    chk("R11", "word", d, word_at(16'h3C3C));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst = 1'b0;
    @(negedge clk);
    test_read(16'h1234);
    test_read(16'h0000);
    test_read(16'hFFFF);
    test_read(16'h8001);
    test_busy_start();
    test_no_timeout();
    test_timeout(8'd2);
    test_read(16'h4242);
    test_timeout(8'd6);
    test_read(16'h0101);
    chk("R5", "cycles with two drivers", clash, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule